// File: doc/BRIEF.md
# Rational Shift-Add Multiplier

This block multiplies two rational numbers, each packed into one 32-bit word. The numerator occupies the upper half of the word and the denominator the lower half. Two identical sequential lanes run side by side. One lane forms the product of the two numerators and the other forms the product of the two denominators. Each lane is a shift-and-add multiplier: an adder, a product register that starts at zero, and a multiplier shift register. Both lanes step together under one shared step counter. A run takes one step per bit of a half-word, which is 16 steps at the default width.

Division uses the same datapath. When the reciprocal input is high on the cycle a run is accepted, the second operand's numerator and denominator swap places before they load. The lanes then form the cross products, giving the quotient. Only the low half-word of each lane product is kept. Operands should therefore stay within 8 bits per field if the result must be exact.

Control is plain: a one-cycle start request, an enable that stalls or advances the run, and a one-cycle done pulse. There is no stream handshake. The result word holds its value after done until the next accepted start. No back-pressure is needed, because a consumer may read the result at any time before it issues another start.

Top module: `ratmul_core`

## Requirements
- R1: After reset, `prod` is 0 and `done` is 0.
- R2: In `op_a`, `op_b` and `prod`, bits 31:16 hold the numerator and bits 15:0 hold the denominator.
- R3: With `recip` low at acceptance, the result numerator is (a_num * b_num) mod 2^16 and the result denominator is (a_den * b_den) mod 2^16.
- R4: With `recip` high at acceptance, the result numerator is (a_num * b_den) mod 2^16 and the result denominator is (a_den * b_num) mod 2^16. For example, 3/2 divided by 7/5 gives 0x000F/0x000E.
- R5: A start is accepted on a rising edge where `start` and `en` are both high and no run is in progress. With `en` held high, `done` rises on the 16th rising edge after the accepting edge.
- R6: `done` is high for exactly one cycle per run.
- R7: A `start` request made while a run is in progress is ignored. It has no effect on the run's result or timing, and no second run follows it.
- R8: A rising edge with `en` low while a run is in progress does not advance the run. Each such edge delays `done` by one cycle and leaves the result unchanged.
- R9: Outside a run, `prod` keeps its value until the next accepted start. A `start` request made while `en` is low is not accepted.
- R10: Truncation keeps the low 16 bits of the full product. For example, 0xFFFF times 0xFFFF gives 0x0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Advances a run and qualifies start |
| start | input | 1 | Request to begin a run |
| recip | input | 1 | Swap numerator and denominator of `op_b` (divide) |
| op_a | input | 32 | First rational operand |
| op_b | input | 32 | Second rational operand |
| prod | output | 32 | Rational result |
| done | output | 1 | One-cycle pulse when a result is complete |

## Verification
A product register that is not cleared on load, or a missed shift of the multiplier register, corrupts the low result bits. That corruption appears on `prod` at the `done` pulse of the same run, so the first vector after the fault reveals it. A step counter that is off by one moves `done` by a cycle, and it also leaves the multiplier register misaligned, so both the latency check and the value check catch it. A swap applied to the wrong operand, or sampled at the wrong time, changes only the results of division runs. Running mixed multiply and divide sweeps, with stalls and with ignored starts, exposes these faults within one operation.

// File: rtl/ratmul_pkg.sv
package ratmul_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  localparam int unsigned LANE_COUNT = 2;

endpackage

// File: rtl/ratmul_opsel.sv
module ratmul_opsel #(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned RAT_W = 2 * HALF_W,
  localparam int unsigned LANES = ratmul_pkg::LANE_COUNT
) (
  input  logic [RAT_W-1:0]             a_word,
  input  logic [RAT_W-1:0]             b_word,
  input  logic                         recip,
  output logic [LANES-1:0][HALF_W-1:0] mcand,
  output logic [LANES-1:0][HALF_W-1:0] mplier
);

  // lane 1 = numerator (upper half), lane 0 = denominator (lower half)
  for (genvar g = 0; g < LANES; g++) begin : g_lane_sel
    assign mcand[g]  = a_word[g*HALF_W +: HALF_W];
    assign mplier[g] = recip ? b_word[(LANES-1-g)*HALF_W +: HALF_W]
                             : b_word[g*HALF_W +: HALF_W];
  end

endmodule

// File: rtl/ratmul_seq.sv
module ratmul_seq #(
  parameter int unsigned STEPS = 16,
  localparam int unsigned CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  import ratmul_pkg::*;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign busy = (state_q == SEQ_RUN);
  assign load = !busy && en && start;
  assign step = busy && en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        state_q <= SEQ_RUN;
        cnt_q   <= '0;
      end else if (step) begin
        if (cnt_q == LAST) begin
          state_q <= SEQ_IDLE;
          done    <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: the final enabled step ends the run and raises done
  p_run_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && en && cnt_q == LAST) |=> (done && !busy));

  // R7: a request during a run neither restarts nor ends it early
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && cnt_q != LAST) |=> (busy && !done));

  // R8: with enable low the step count does not move
  p_cnt_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !en) |=> (busy && $stable(cnt_q)));

endmodule

// File: rtl/ratmul_lane.sv
module ratmul_lane #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] mcand_in,
  input  logic [W-1:0] mplier_in,
  output logic [W-1:0] low_o
);

  logic [W-1:0] md_q;   // multiplicand
  logic [W-1:0] pr_q;   // product (high) register
  logic [W-1:0] mr_q;   // multiplier shift register, ends holding low half
  logic [W:0]   sum;

  always_comb begin
    sum = {1'b0, pr_q} + {1'b0, (md_q & {W{mr_q[0]}})};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      md_q <= '0;
      pr_q <= '0;
      mr_q <= '0;
    end else if (load) begin
      md_q <= mcand_in;
      pr_q <= '0;
      mr_q <= mplier_in;
    end else if (step) begin
      pr_q <= sum[W:1];
      mr_q <= {sum[0], mr_q[W-1:1]};
    end
  end

  assign low_o = mr_q;

  // R3: a new run begins from a cleared product register
  p_pr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (pr_q == '0));

  // R8: without a step or load, no lane register moves
  p_lane_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> ($stable(pr_q) && $stable(mr_q) && $stable(md_q)));

endmodule

// File: rtl/ratmul_core.sv
module ratmul_core #(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned RAT_W = 2 * HALF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start,
  input  logic             recip,
  input  logic [RAT_W-1:0] op_a,
  input  logic [RAT_W-1:0] op_b,
  output logic [RAT_W-1:0] prod,
  output logic             done
);
  localparam int unsigned LANES = ratmul_pkg::LANE_COUNT;

  logic                         load;
  logic                         step;
  logic                         busy;
  logic [LANES-1:0][HALF_W-1:0] mcand;
  logic [LANES-1:0][HALF_W-1:0] mplier;
  logic [LANES-1:0][HALF_W-1:0] lane_low;

  ratmul_opsel #(.HALF_W(HALF_W)) opsel_i (
    .a_word (op_a),
    .b_word (op_b),
    .recip  (recip),
    .mcand  (mcand),
    .mplier (mplier)
  );

  ratmul_seq #(.STEPS(HALF_W)) seq_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ratmul_lane #(.W(HALF_W)) lane_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .step      (step),
      .mcand_in  (mcand[g]),
      .mplier_in (mplier[g]),
      .low_o     (lane_low[g])
    );
  end

  // R2: numerator lane in the upper half, denominator lane in the lower half
  assign prod = lane_low;

  // R9: the result word holds while idle and no start is accepted
  p_prod_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load) |=> $stable(prod));

  // R6: done only follows a running cycle
  p_done_after_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/ratmul_core_tb_top.sv
module ratmul_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int STEPS      = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        start = 1'b0;
  logic        recip = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [31:0] prod;
  logic        done;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ratmul_core dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .recip(recip),
    .op_a(op_a), .op_b(op_b), .prod(prod), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b, input logic rc);
    logic [31:0] pn, pd;
    pn = a[31:16] * (rc ? b[15:0] : b[31:16]);
    pd = a[15:0]  * (rc ? b[31:16] : b[15:0]);
    return {pn[15:0], pd[15:0]};
  endfunction

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic rc);
    @(negedge clk);
    op_a = a; op_b = b; recip = rc; en = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; op_a = ~a; op_b = ~b; recip = ~rc;
  endtask

  task automatic wait_done(output int n);
    n = 1;
    while (!done && n < 80) begin
      @(negedge clk);
      if (!done) n++;
    end
  endtask

  task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b, input logic rc);
    int n;
    issue(a, b, rc);
    wait_done(n);
    chk({req, " latency R5"}, 32'(n), 32'(STEPS));
    chk(req, prod, model(a, b, rc));
    @(negedge clk);
    chk("R6 done single pulse", {31'd0, done}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] held;
    logic [31:0] lfsr;
    int n;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset prod", prod, 32'd0);
    chk("R1 reset done", {31'd0, done}, 32'd0);

    // R2/R3/R4 worked examples
    run_op("R3 multiply 3/2*7/5", 32'h0003_0002, 32'h0007_0005, 1'b0);
    chk("R2 packed 21/10", prod, 32'h0015_000A);
    run_op("R4 divide 3/2 / 7/5", 32'h0003_0002, 32'h0007_0005, 1'b1);
    chk("R2 packed 15/14", prod, 32'h000F_000E);

    // R10 truncation
    run_op("R10 trunc ffff", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    chk("R10 ffff*ffff low", prod, 32'h0001_0001);
    run_op("R10 trunc shift", 32'h1234_0100, 32'h0100_1234, 1'b0);
    chk("R10 0x1234*0x100", prod, 32'h3400_3400);

    // R3/R4 grid sweep over 8-bit fields
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        logic [31:0] a, b;
        a = {8'd0, 8'(i * 17), 8'd0, 8'(255 - i * 13)};
        b = {8'd0, 8'(j * 15 + 1), 8'd0, 8'(j * 7 + 3)};
        run_op(((i + j) % 2 == 1) ? "R4 sweep" : "R3 sweep", a, b, 1'((i + j) % 2));
      end
    end

    // full-width pseudo-random operands
    lfsr = 32'hACE1_1357;
    for (int k = 0; k < 64; k++) begin
      logic [31:0] a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      run_op("R3/R4 random", a, lfsr, lfsr[7]);
    end

    // R7: start during a run is ignored
    issue(32'h0009_0004, 32'h000B_0003, 1'b0);
    n = 1;
    while (!done && n < 80) begin
      if (n == 5) begin op_a = 32'h0002_0002; op_b = 32'h0002_0002; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
      if (!done) n++;
    end
    start = 1'b0;
    chk("R7 latency unchanged", 32'(n), 32'(STEPS));
    chk("R7 first result kept", prod, 32'h0063_000C);
    held = prod;
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      if (done) chk("R7 no second run", {31'd0, done}, 32'd0);
    end
    chk("R7 result unchanged", prod, held);

    // R8: seven stalled edges delay done by seven cycles
    issue(32'h000D_0006, 32'h0005_000B, 1'b1);
    n = 1;
    while (!done && n < 80) begin
      en = !(n >= 4 && n < 11);
      @(negedge clk);
      if (!done) n++;
    end
    en = 1'b1;
    chk("R8 stalled latency", 32'(n), 32'(STEPS + 7));
    chk("R8 stalled result", prod, model(32'h000D_0006, 32'h0005_000B, 1'b1));

    // R9: hold after done; start with en low is not accepted
    held = prod;
    @(negedge clk);
    op_a = 32'h0011_0011; op_b = 32'h0011_0011; recip = 1'b0;
    en = 1'b0; start = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (done) chk("R9 no run with en low", {31'd0, done}, 32'd0);
    end
    chk("R9 prod held with en low start", prod, held);
    start = 1'b0; en = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9 prod held idle", prod, held);
    chk("R9 no done idle", {31'd0, done}, 32'd0);

    // mid-run reset returns to R1 state
    issue(32'h0003_0003, 32'h0003_0003, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset mid-run prod", prod, 32'd0);
    chk("R1 reset mid-run done", {31'd0, done}, 32'd0);
    run_op("R3 after reset", 32'h0006_0007, 32'h0008_0009, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule